// File: doc/BRIEF.md
# ARINC 429 word assembler

This block turns the two decoded return-to-zero signals of an ARINC 429 receive path into finished 32-bit words. One signal marks a one bit and the other marks a zero bit; the null between bits is both signals inactive. Each new bit goes into the next position of an input register. A quiet line lasting a fixed number of gap-detection ticks is a word gap. At each gap the block hands the assembled word to the receive buffer, along with a flag that says whether exactly 32 bits arrived. Optionally, bit 32 of the word is replaced by the odd-parity verdict.

Reset holds the block in its initial state. After reset is released, the block keeps discarding input until the first word gap has passed, so a word already in flight is never delivered in part. A test-mode select swaps in two active-low digital inputs in place of the line signals. This lets the same assembly logic be driven from another digital source.

Top module: `a429_word_asm`

## Requirements
- R1: Bits are taken on the first clock in which a line signal becomes active after a null. `line_a` alone is a one and `line_b` alone is a zero. Both inactive is the null. A bit is taken only once, however long its signal stays active.
- R2: The first bit after a gap is stored in bit 0 of `word_data` and each later bit one position higher. Positions not received read 0. Bits beyond the 32nd are dropped.
- R3: A word gap is declared on the `GAP_TICKS`-th (default 17) `gap_tick` pulse counted while both selected signals stay inactive. Any line activity restarts the count, so 16 ticks followed by more bits do not split a word.
- R4: Each non-initial gap produces `word_valid` high for exactly one clock. `word_data` and `word_err` are updated in that clock and hold until the next pulse.
- R5: With `par_en` high, a word with an odd number of ones is delivered unchanged. A word with an even number of ones is delivered with bit 31 forced to 1.
- R6: With `par_en` low, bit 31 is the 32nd received bit, whatever the parity.
- R7: `word_err` is 1 when the bit count since the previous gap was not 32, and 0 when it was exactly 32.
- R8: While `rst` is high, `word_valid`, `word_err` and `word_data` are 0. After release, the bits before the first gap are discarded and that gap produces no pulse.
- R9: With `test_en` high, `test_a` low is a one and `test_b` low is a zero. Both high is the null. `line_a` and `line_b` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset and initialization |
| gap_tick | input | 1 | One-clock enable per gap-detection period |
| line_a | input | 1 | Decoded "one" line signal, active high |
| line_b | input | 1 | Decoded "zero" line signal, active high |
| test_en | input | 1 | Selects the test inputs instead of the line signals |
| test_a | input | 1 | Test "one" input, active low |
| test_b | input | 1 | Test "zero" input, active low |
| par_en | input | 1 | Enables the odd-parity check on bit 31 |
| word_valid | output | 1 | One-clock pulse when a word is handed over |
| word_data | output | 32 | Assembled word |
| word_err | output | 1 | Bit count of the last word was not 32 |

## Verification
The bench drives words of 32, 31, 33 and 5 bits with mixed bit patterns. These show the bit ordering, the zero fill of positions that were not received, the discarding of extra bits, and when the count flag sets and clears. It sends the same values with parity on and off, using words of odd weight and of even weight with bit 31 both clear and set. This separates the forced bit from the raw 32nd bit. A pause of 16 ticks inside a word and a partial word straddling reset show that only a full gap closes a word and that the arming gap is swallowed. A test-mode word, sent while `line_b` is held active, only arrives if the line inputs are truly ignored.

// File: rtl/a429_pkg.sv
package a429_pkg;

    localparam int DEF_WORD_W    = 32;
    localparam int DEF_GAP_TICKS = 17;

    // Symbol seen on the selected pair of signals in one clock.
    typedef enum logic [1:0] {
        SYM_NULL = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_ZERO = 2'b10,
        SYM_BOTH = 2'b11
    } sym_e;

    // Bit event passed from the front end to the accumulator.
    typedef struct packed {
        logic strobe;
        logic value;
    } bit_ev_t;

    function automatic sym_e classify(input logic one_act, input logic zero_act);
        case ({zero_act, one_act})
            2'b01:   return SYM_ONE;
            2'b10:   return SYM_ZERO;
            2'b11:   return SYM_BOTH;
            default: return SYM_NULL;
        endcase
    endfunction

endpackage

// File: rtl/a429_line_sel.sv
module a429_line_sel
    import a429_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    line_a,
    input  logic    line_b,
    input  logic    test_en,
    input  logic    test_a,
    input  logic    test_b,
    output bit_ev_t ev,
    output logic    idle
);

    logic sel_one;
    logic sel_zero;
    sym_e cur_q;
    sym_e prev_q;

    // Test inputs are active low; both high is the null.
    always_comb begin
        sel_one  = test_en ? ~test_a : line_a;
        sel_zero = test_en ? ~test_b : line_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= SYM_NULL;
            prev_q <= SYM_NULL;
        end else begin
            cur_q  <= classify(sel_one, sel_zero);
            prev_q <= cur_q;
        end
    end

    always_comb begin
        ev.strobe = (cur_q != SYM_NULL) && (prev_q == SYM_NULL);
        ev.value  = (cur_q == SYM_ONE);
        idle      = (cur_q == SYM_NULL);
    end

endmodule

// File: rtl/a429_gap_det.sv
module a429_gap_det #(
    parameter int GAP_TICKS = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic idle,
    output logic gap
);

    localparam int CW = $clog2(GAP_TICKS + 1);

    logic [CW-1:0] quiet_cnt;

    // Fires once per quiet period: the counter then saturates.
    always_comb gap = idle && tick && (quiet_cnt == CW'(GAP_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !idle) begin
            quiet_cnt <= '0;
        end else if (tick && (quiet_cnt != CW'(GAP_TICKS))) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/a429_shift_acc.sv
module a429_shift_acc
    import a429_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_ev_t           ev,
    input  logic              gap,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  count
);

    localparam int IDX_W = $clog2(WORD_W);

    always_ff @(posedge clk) begin
        if (rst || gap) begin
            word  <= '0;
            count <= '0;
        end else if (ev.strobe) begin
            if (count < CNT_W'(WORD_W)) begin
                word[count[IDX_W-1:0]] <= ev.value;
            end
            if (count != '1) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/a429_word_asm.sv
module a429_word_asm
    import a429_pkg::*;
#(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int GAP_TICKS = DEF_GAP_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gap_tick,
    input  logic              line_a,
    input  logic              line_b,
    input  logic              test_en,
    input  logic              test_a,
    input  logic              test_b,
    input  logic              par_en,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              word_err
);

    localparam int CNT_W = $clog2(WORD_W) + 1;

    bit_ev_t           ev;
    logic              idle;
    logic              gap;
    logic [WORD_W-1:0] acc_word;
    logic [CNT_W-1:0]  acc_cnt;
    logic [WORD_W-1:0] checked;
    logic              armed;

    a429_line_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .line_a  (line_a),
        .line_b  (line_b),
        .test_en (test_en),
        .test_a  (test_a),
        .test_b  (test_b),
        .ev      (ev),
        .idle    (idle)
    );

    a429_gap_det #(.GAP_TICKS(GAP_TICKS)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .tick (gap_tick),
        .idle (idle),
        .gap  (gap)
    );

    a429_shift_acc #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .gap   (gap),
        .word  (acc_word),
        .count (acc_cnt)
    );

    // Even weight fails odd parity: the top bit carries the verdict.
    always_comb begin
        checked = acc_word;
        if (par_en && !(^acc_word)) begin
            checked[WORD_W-1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_err   <= 1'b0;
        end else begin
            word_valid <= gap && armed;
            if (gap) begin
                armed <= 1'b1;
            end
            if (gap && armed) begin
                word_data <= checked;
                word_err  <= (acc_cnt != CNT_W'(WORD_W));
            end
        end
    end

endmodule

// File: rtl/a429_word_asm_chk.sv
module a429_word_asm_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              gap_tick,
    input logic              par_en,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              word_err
);

    // R4: the hand-over strobe lasts a single clock
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R4: outputs change only together with the strobe
    p_hold_between_r4: assert property (@(posedge clk) disable iff (rst)
        (!word_valid && !$past(rst)) |-> ($stable(word_data) && $stable(word_err)));

    // R3: a word is only closed on a gap-detection tick
    p_gap_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(gap_tick));

    // R5: with parity on, an even-weight word always shows bit 31 set
    p_parity_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (word_valid && $past(par_en) && !(^word_data)) |-> word_data[WORD_W-1]);

    // R8: reset clears the outputs
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!word_valid && !word_err && (word_data == '0)));

endmodule

bind a429_word_asm a429_word_asm_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gap_tick   (gap_tick),
    .par_en     (par_en),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_err   (word_err)
);

// File: tb/sim_a429_word_asm.sv
`timescale 1ns/1ps
module sim_a429_word_asm;

    localparam int GAP = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gap_tick = 1'b0;
    logic        line_a = 1'b0;
    logic        line_b = 1'b0;
    logic        test_en = 1'b0;
    logic        test_a = 1'b1;
    logic        test_b = 1'b1;
    logic        par_en = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] q_d[$];
    logic        q_e[$];
    string       q_t[$];

    always #10 clk = ~clk;

    a429_word_asm u0 (
        .clk        (clk),
        .rst        (rst),
        .gap_tick   (gap_tick),
        .line_a     (line_a),
        .line_b     (line_b),
        .test_en    (test_en),
        .test_a     (test_a),
        .test_b     (test_b),
        .par_en     (par_en),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_err   (word_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected word: {count error, data}
    function automatic logic [32:0] model(input logic [63:0] bits, input int n, input logic pe);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < n && i < 32; i++) w[i] = bits[i];
        if (pe && !(^w)) w[31] = 1'b1;
        return {(n != 32), w};
    endfunction

    task automatic send_bit(input logic v);
        @(negedge clk);
        if (test_en) begin
            test_a = ~v;
            test_b = v;
        end else begin
            line_a = v;
            line_b = ~v;
        end
        repeat (2) @(negedge clk);
        if (test_en) begin
            test_a = 1'b1;
            test_b = 1'b1;
        end else begin
            line_a = 1'b0;
            line_b = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            gap_tick = 1'b1;
            @(negedge clk);
            gap_tick = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] bits, input int n, input int first);
        for (int i = first; i < n; i++) send_bit(bits[i]);
    endtask

    task automatic expect_word(input logic [63:0] bits, input int n, input logic pe, input string tag);
        logic [32:0] m;
        m = model(bits, n, pe);
        q_d.push_back(m[31:0]);
        q_e.push_back(m[32]);
        q_t.push_back(tag);
    endtask

    task automatic send_word(input logic [63:0] bits, input int n, input logic pe, input bit push, input string tag);
        @(negedge clk);
        par_en = pe;
        send_bits(bits, n, 0);
        if (push) expect_word(bits, n, pe, tag);
        ticks(GAP);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (q_d.size() == 0) begin
                check(1'b0, "R4/R8 unexpected word", word_data, 32'h0);
            end else begin
                logic [31:0] ed;
                logic        ee;
                string       tg;
                ed = q_d.pop_front();
                ee = q_e.pop_front();
                tg = q_t.pop_front();
                check(word_data === ed, {tg, " data"}, word_data, ed);
                check(word_err === ee, {tg, " R7 err"}, {31'd0, word_err}, {31'd0, ee});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(word_valid === 1'b0, "R8 reset valid", {31'd0, word_valid}, 32'h0);
        check(word_err === 1'b0, "R8 reset err", {31'd0, word_err}, 32'h0);
        check(word_data === 32'h0, "R8 reset data", word_data, 32'h0);
        rst = 1'b0;

        // R8: a partial word before the arming gap is swallowed
        send_word(64'h3FF, 10, 1'b0, 1'b0, "R8 arm");

        // R1 R2 R6: plain words, parity off
        send_word(64'h1234_5678, 32, 1'b0, 1'b1, "R1 R2");
        send_word(64'h0000_0003, 32, 1'b0, 1'b1, "R6 even kept");
        send_word(64'hF0F0_0F0F, 32, 1'b0, 1'b1, "R2 pattern");

        // R5: parity on
        send_word(64'h1234_5678, 32, 1'b1, 1'b1, "R5 odd");
        send_word(64'h0000_0003, 32, 1'b1, 1'b1, "R5 even forced");
        send_word(64'h8000_0001, 32, 1'b1, 1'b1, "R5 even top set");

        // R7 R2: wrong counts, then recovery
        send_word(64'h7FFF_FFFF, 31, 1'b0, 1'b1, "R7 short");
        send_word(64'h1_C000_0001, 33, 1'b0, 1'b1, "R7 long R2 drop");
        send_word(64'h0055_AA00, 32, 1'b0, 1'b1, "R7 clear");

        // R3: sixteen quiet ticks inside a word do not close it
        @(negedge clk);
        par_en = 1'b0;
        send_bits(64'hCAFE_1234, 10, 0);
        ticks(GAP - 1);
        send_bits(64'hCAFE_1234, 32, 10);
        expect_word(64'hCAFE_1234, 32, 1'b0, "R3 split");
        ticks(GAP);

        // R8: reset clears the error flag and re-arms
        send_word(64'h15, 5, 1'b0, 1'b1, "R7 five");
        repeat (2) @(negedge clk);
        check(word_err === 1'b1, "R7 flag held", {31'd0, word_err}, 32'h1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(word_err === 1'b0, "R8 err cleared", {31'd0, word_err}, 32'h0);
        check(word_data === 32'h0, "R8 data cleared", word_data, 32'h0);
        send_word(64'hDEAD_BEEF, 32, 1'b0, 1'b0, "R8 rearm");
        send_word(64'h0BAD_F00D, 32, 1'b0, 1'b1, "R8 after arm");

        // R9: test inputs drive the logic, line_b held active is ignored
        @(negedge clk);
        test_a  = 1'b1;
        test_b  = 1'b1;
        test_en = 1'b1;
        line_b  = 1'b1;
        repeat (3) @(negedge clk);
        send_word(64'hA5C3_0F1E, 32, 1'b0, 1'b1, "R9 test");
        @(negedge clk);
        test_en = 1'b0;
        line_b  = 1'b0;
        repeat (4) @(negedge clk);

        check(q_d.size() == 0, "R4 all words seen", q_d.size(), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule